// File: doc/BRIEF.md
# Memory-Mapped Asynchronous Serial Port

This block is a word-addressed serial port for a processor bus. Software programs a baud reload value and a control word, then moves characters through one-deep transmit and receive holding buffers while polling a status word. The transmitter sends 8-bit characters with a start bit, least significant bit first, an optional odd parity bit and one stop bit. The receiver rebuilds characters from the same frame shape and records framing or parity faults.

Both directions are timed by an oversampling tick at sixteen ticks per bit. A control bit picks how that tick is made. In integer mode, a reload counter divides the clock. In fractional mode, a phase accumulator adds the reload value every cycle and ticks on each carry.

The interrupt-enable, guard-time and timeout words are plain storage. Bus reads are registered, so read data is valid on the cycle after the read strobe.

Top module: `sercon_top`

## Requirements
- R1: After reset, the status word reads 0, the control and baud words read 0, and `txd` is high.
- R2: The interrupt-enable (word 4), guard-time (word 6) and timeout (word 7) words read back all 32 written bits. The baud word (word 0) and the control word (word 3) read back the low 16 written bits, with the upper bits reading as 0.
- R3: A transmitted frame is laid out as follows: a low start bit, then 8 data bits LSB first, then a parity bit if control bit 5 is 1, then a high stop bit. The parity bit makes the count of ones across the data and parity bits odd. Every bit lasts 16 ticks.
- R4: When control bit 12 is 0, one tick occurs every max(reload,1) clocks. When control bit 12 is 1, the tick rate is clock × reload / 65536. For example, a reload of 2 in integer mode gives 32-clock bits, and a reload of 16384 in fractional mode gives 64-clock bits.
- R5: A write to the transmit buffer (word 1) sets status bit 9. That bit clears when the shifter takes the character. A write to word 1 while bit 9 is set is dropped.
- R6: A received frame stores its character and sets status bit 0. A read of the receive buffer (word 2) returns the character in bits 7:0 and clears status bit 0.
- R7: The receiver samples the start bit on the 8th tick after the line falls. If the line is high at that point, it drops the start and stores nothing.
- R8: Status bit 2 is set by a received frame whose parity is not odd (with control bit 5 = 1) or whose stop bit is low. The character is still stored. Bit 2 is cleared by a read of word 2.
- R9: A write to word 8 with data bit 0 = 1 clears status bit 9, and the pending character is never sent. A write to word 9 with data bit 0 = 1 clears status bits 0 and 2. A write to either word with bit 0 = 0 has no effect.
- R10: While control bit 7 (run) is 0, nothing is sent, `txd` stays high and status bit 9 keeps its value. While control bit 8 (receive enable) is 0, no character is received.
- R11: Read data is placed on `bus_rdata` on the clock edge that samples `bus_rd`, and it holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (4) | Word index |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |

## Verification
The assertions assume three things about the inputs:
- `bus_rd` and `bus_wr` are never high in the same cycle.
- The control word is rewritten only while both shifters are idle.
- The serial input holds each level for several clocks.

The stimulus keeps to these rules. Every bus access is a single strobe driven on the falling edge. Control changes are made only after a frame has been fully captured. Received frames are driven at the same bit time the programmed tick produces. The only short pulses are the deliberate glitch, which is longer than the two-flop synchroniser, and a shortened faulty stop bit.

// File: rtl/sercon_pkg.sv
package sercon_pkg;
  // word indices on the bus
  localparam int A_BAUD  = 0;
  localparam int A_TXBUF = 1;
  localparam int A_RXBUF = 2;
  localparam int A_CTRL  = 3;
  localparam int A_INTEN = 4;
  localparam int A_STAT  = 5;
  localparam int A_GUARD = 6;
  localparam int A_TMO   = 7;
  localparam int A_TXRST = 8;
  localparam int A_RXRST = 9;

  // control word bits
  localparam int CB_PAR  = 5;
  localparam int CB_RUN  = 7;
  localparam int CB_RXEN = 8;
  localparam int CB_FRAC = 12;

  // status word bits
  localparam int SB_RXAV   = 0;
  localparam int SB_ERR    = 2;
  localparam int SB_TXFULL = 9;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_PAR,
    FR_STOP
  } frame_st_t;
endpackage

// File: rtl/sercon_baud.sv
module sercon_baud #(
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              frac,
  input  logic [BAUD_W-1:0] reload,
  output logic              tick
);
  logic [BAUD_W-1:0] cnt;
  logic [BAUD_W-1:0] acc;
  logic [BAUD_W:0]   acc_sum;

  assign acc_sum = {1'b0, acc} + {1'b0, reload};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      acc  <= '0;
      tick <= 1'b0;
    end else if (frac) begin
      acc  <= acc_sum[BAUD_W-1:0];
      tick <= acc_sum[BAUD_W];
    end else if (cnt == '0) begin
      tick <= 1'b1;
      cnt  <= (reload == '0) ? '0 : reload - 1'b1;
    end else begin
      tick <= 1'b0;
      cnt  <= cnt - 1'b1;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (run && !frac && tick && reload > 1 && $stable(reload) && $past(run) && !$past(frac)) |=> !tick); // R4
endmodule

// File: rtl/sercon_tx.sv
module sercon_tx
  import sercon_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              par_en,
  input  logic              buf_full,
  input  logic [CHAR_W-1:0] buf_data,
  output logic              load,
  output logic              txd
);
  localparam int PH_W = $clog2(OVS);
  localparam int BN_W = $clog2(CHAR_W);
  localparam logic [PH_W-1:0] PH_END  = PH_W'(OVS - 1);
  localparam logic [BN_W-1:0] BN_LAST = BN_W'(CHAR_W - 1);

  frame_st_t         st;
  logic [PH_W-1:0]   phase;
  logic [BN_W-1:0]   bitn;
  logic [CHAR_W-1:0] sh;
  logic              par;

  assign load = run && (st == FR_IDLE) && buf_full;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      st    <= FR_IDLE;
      phase <= '0;
      bitn  <= '0;
      sh    <= '0;
      par   <= 1'b1;
    end else if (load) begin
      sh    <= buf_data;
      par   <= ~^buf_data;
      st    <= FR_START;
      phase <= '0;
      bitn  <= '0;
    end else if (tick && st != FR_IDLE) begin
      if (phase == PH_END) begin
        phase <= '0;
        case (st)
          FR_START: st <= FR_DATA;
          FR_DATA: begin
            sh <= sh >> 1;
            if (bitn == BN_LAST) st <= par_en ? FR_PAR : FR_STOP;
            else bitn <= bitn + 1'b1;
          end
          FR_PAR:  st <= FR_STOP;
          default: st <= FR_IDLE;
        endcase
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) txd <= 1'b1;
    else begin
      case (st)
        FR_START: txd <= 1'b0;
        FR_DATA:  txd <= sh[0];
        FR_PAR:   txd <= par;
        default:  txd <= 1'b1;
      endcase
    end
  end

  AST_TXD_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run |=> txd); // R10
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
    (st == FR_DATA && $past(st) == FR_START) |-> !txd); // R3
endmodule

// File: rtl/sercon_rx.sv
module sercon_rx
  import sercon_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              par_en,
  input  logic              rxd,
  output logic              done,
  output logic [CHAR_W-1:0] data,
  output logic              bad
);
  localparam int PH_W = $clog2(OVS);
  localparam int BN_W = $clog2(CHAR_W);
  localparam logic [PH_W-1:0] PH_END  = PH_W'(OVS - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS / 2 - 1);
  localparam logic [BN_W-1:0] BN_LAST = BN_W'(CHAR_W - 1);

  logic              rx_m, rx_s;
  frame_st_t         st;
  logic [PH_W-1:0]   phase;
  logic [BN_W-1:0]   bitn;
  logic [CHAR_W-1:0] sh;
  logic              par_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st    <= FR_IDLE;
      phase <= '0;
      bitn  <= '0;
      sh    <= '0;
      par_s <= 1'b0;
      done  <= 1'b0;
      data  <= '0;
      bad   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == FR_IDLE) begin
        if (!rx_s) begin
          st    <= FR_START;
          phase <= '0;
        end
      end else if (tick) begin
        case (st)
          FR_START: begin
            if (phase == PH_MID) begin
              phase <= '0;
              bitn  <= '0;
              st    <= rx_s ? FR_IDLE : FR_DATA;
            end else phase <= phase + 1'b1;
          end
          FR_DATA: begin
            if (phase == PH_END) begin
              phase <= '0;
              sh    <= {rx_s, sh[CHAR_W-1:1]};
              if (bitn == BN_LAST) st <= par_en ? FR_PAR : FR_STOP;
              else bitn <= bitn + 1'b1;
            end else phase <= phase + 1'b1;
          end
          FR_PAR: begin
            if (phase == PH_END) begin
              phase <= '0;
              par_s <= rx_s;
              st    <= FR_STOP;
            end else phase <= phase + 1'b1;
          end
          default: begin
            if (phase == PH_END) begin
              phase <= '0;
              done  <= 1'b1;
              data  <= sh;
              bad   <= !rx_s || (par_en && !(^{sh, par_s}));
              st    <= FR_IDLE;
            end else phase <= phase + 1'b1;
          end
        endcase
      end
    end
  end

  AST_START_CONFIRMED_LOW: assert property (@(posedge clk) disable iff (rst)
    (st == FR_DATA && $past(st) == FR_START) |-> !$past(rx_s)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
endmodule

// File: rtl/sercon_top.sv
module sercon_top
  import sercon_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 16,
  parameter int BAUD_W = 16,
  parameter int CHAR_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rxd,
  output logic              txd
);
  localparam logic [ADDR_W-1:0] AD_BAUD  = ADDR_W'(A_BAUD);
  localparam logic [ADDR_W-1:0] AD_TXBUF = ADDR_W'(A_TXBUF);
  localparam logic [ADDR_W-1:0] AD_RXBUF = ADDR_W'(A_RXBUF);
  localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_INTEN = ADDR_W'(A_INTEN);
  localparam logic [ADDR_W-1:0] AD_STAT  = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] AD_GUARD = ADDR_W'(A_GUARD);
  localparam logic [ADDR_W-1:0] AD_TMO   = ADDR_W'(A_TMO);
  localparam logic [ADDR_W-1:0] AD_TXRST = ADDR_W'(A_TXRST);
  localparam logic [ADDR_W-1:0] AD_RXRST = ADDR_W'(A_RXRST);

  logic [BAUD_W-1:0] baud_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] inten_q, guard_q, tmo_q;
  logic [CHAR_W-1:0] txbuf_q, rxbuf_q;
  logic              tx_full, rx_avail, rx_err;
  logic [DATA_W-1:0] rd_mux, stat_w, rdata_q;

  logic              tick, tx_load, rx_done, rx_bad;
  logic [CHAR_W-1:0] rx_data;
  logic              run, rx_en, par_en, frac;

  assign run    = ctrl_q[CB_RUN];
  assign rx_en  = ctrl_q[CB_RUN] && ctrl_q[CB_RXEN];
  assign par_en = ctrl_q[CB_PAR];
  assign frac   = ctrl_q[CB_FRAC];

  logic wr_txbuf, wr_txrst, wr_rxrst, rd_rxbuf;
  assign wr_txbuf = bus_wr && bus_addr == AD_TXBUF;
  assign wr_txrst = bus_wr && bus_addr == AD_TXRST && bus_wdata[0];
  assign wr_rxrst = bus_wr && bus_addr == AD_RXRST && bus_wdata[0];
  assign rd_rxbuf = bus_rd && bus_addr == AD_RXBUF;

  sercon_baud #(.BAUD_W(BAUD_W)) u_baud (
    .clk(clk), .rst(rst), .run(run), .frac(frac), .reload(baud_q), .tick(tick)
  );

  sercon_tx #(.CHAR_W(CHAR_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .par_en(par_en),
    .buf_full(tx_full), .buf_data(txbuf_q), .load(tx_load), .txd(txd)
  );

  sercon_rx #(.CHAR_W(CHAR_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .en(rx_en), .tick(tick), .par_en(par_en),
    .rxd(rxd), .done(rx_done), .data(rx_data), .bad(rx_bad)
  );

  // configuration and storage words
  always_ff @(posedge clk) begin
    if (rst) begin
      baud_q  <= '0;
      ctrl_q  <= '0;
      inten_q <= '0;
      guard_q <= '0;
      tmo_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        AD_BAUD:  baud_q  <= bus_wdata[BAUD_W-1:0];
        AD_CTRL:  ctrl_q  <= bus_wdata[CTRL_W-1:0];
        AD_INTEN: inten_q <= bus_wdata;
        AD_GUARD: guard_q <= bus_wdata;
        AD_TMO:   tmo_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  // transmit holding buffer
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_full <= 1'b0;
      txbuf_q <= '0;
    end else if (tx_load || wr_txrst) begin
      tx_full <= 1'b0;
    end else if (wr_txbuf && !tx_full) begin
      tx_full <= 1'b1;
      txbuf_q <= bus_wdata[CHAR_W-1:0];
    end
  end

  // receive holding buffer
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_avail <= 1'b0;
      rx_err   <= 1'b0;
      rxbuf_q  <= '0;
    end else if (rx_done) begin
      rx_avail <= 1'b1;
      rxbuf_q  <= rx_data;
      rx_err   <= rx_bad || (rx_err && !rd_rxbuf && !wr_rxrst);
    end else if (rd_rxbuf || wr_rxrst) begin
      rx_avail <= 1'b0;
      rx_err   <= 1'b0;
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[SB_RXAV]   = rx_avail;
    stat_w[SB_ERR]    = rx_err;
    stat_w[SB_TXFULL] = tx_full;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AD_BAUD:  rd_mux[BAUD_W-1:0] = baud_q;
      AD_RXBUF: rd_mux[CHAR_W-1:0] = rxbuf_q;
      AD_CTRL:  rd_mux[CTRL_W-1:0] = ctrl_q;
      AD_INTEN: rd_mux = inten_q;
      AD_STAT:  rd_mux = stat_w;
      AD_GUARD: rd_mux = guard_q;
      AD_TMO:   rd_mux = tmo_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;

  AST_LOAD_FREES_BUFFER: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_full); // R5
  AST_FULL_BUFFER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (tx_full && !tx_load && !wr_txrst) |=> (tx_full && $stable(txbuf_q))); // R5
  AST_RXREAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_rxbuf && !rx_done) |=> (!rx_avail && !rx_err)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R11
  AST_STOPPED_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tx_load); // R10
endmodule

// File: tb/sercon_top_tb.sv
`timescale 1ns/1ps
module sercon_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        txd, rxd_w;
  logic        rx_drv = 1'b1, loop_en = 1'b0;
  int total = 0, bad = 0;
  bit done_flag = 0;

  localparam logic [31:0] C_BASE = 32'h0000_0189; // run, rx enable, 8-bit, one stop
  localparam logic [31:0] C_PAR  = 32'h0000_0020;
  localparam logic [31:0] C_FRAC = 32'h0000_1000;

  // byte, parity enable, expected parity bit
  localparam logic [9:0] VEC [6] = '{
    {8'h00, 1'b1, 1'b1}, {8'hFF, 1'b1, 1'b1}, {8'h01, 1'b1, 1'b0},
    {8'hA5, 1'b0, 1'b0}, {8'h80, 1'b1, 1'b0}, {8'h3C, 1'b0, 1'b0}
  };

  always #10 clk = ~clk;
  assign rxd_w = loop_en ? txd : rx_drv;

  sercon_top u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd_w), .txd(txd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // waits for a start edge, then samples each bit at its middle
  task automatic cap_tx(input int bt, input logic has_par, output logic found,
                        output logic st, output logic [7:0] d, output logic p, output logic sp);
    found = 1'b0; st = 1'b1; d = '0; p = 1'b0; sp = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!txd) begin found = 1'b1; break; end
    end
    if (found) begin
      repeat (bt / 2) @(negedge clk);
      st = txd;
      for (int i = 0; i < 8; i++) begin
        repeat (bt) @(negedge clk);
        d[i] = txd;
      end
      if (has_par) begin repeat (bt) @(negedge clk); p = txd; end
      repeat (bt) @(negedge clk);
      sp = txd;
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input logic has_par, input logic pb, input logic stop_low);
    @(negedge clk);
    rx_drv = 1'b0; repeat (32) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx_drv = b[i]; repeat (32) @(negedge clk); end
    if (has_par) begin rx_drv = pb; repeat (32) @(negedge clk); end
    if (stop_low) begin rx_drv = 1'b0; repeat (24) @(negedge clk); rx_drv = 1'b1; repeat (48) @(negedge clk); end
    else begin rx_drv = 1'b1; repeat (64) @(negedge clk); end
  endtask

  task automatic wait_rx(output logic [31:0] s);
    s = '0;
    for (int i = 0; i < 1000; i++) begin
      rd(4'd5, s);
      if (s[0]) break;
    end
  endtask

  task automatic low_cycles(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (!txd) cnt++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, s;
    logic found, st, p, sp;
    logic [7:0] d;
    int lc;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 txd idle", {31'd0, txd}, 32'd1);
    rd(4'd5, r); chk("R1 status", r, 32'd0);
    rd(4'd3, r); chk("R1 control", r, 32'd0);
    rd(4'd0, r); chk("R1 baud", r, 32'd0);

    // R2 storage readback
    wr(4'd0, 32'h1234_ABCD); rd(4'd0, r); chk("R2 baud", r, 32'h0000_ABCD);
    wr(4'd4, 32'h5555_0F0F); rd(4'd4, r); chk("R2 inten", r, 32'h5555_0F0F);
    wr(4'd6, 32'hDEAD_BEEF); rd(4'd6, r); chk("R2 guard", r, 32'hDEAD_BEEF);
    wr(4'd7, 32'h0BAD_F00D); rd(4'd7, r); chk("R2 timeout", r, 32'h0BAD_F00D);
    wr(4'd3, 32'hFFFF_1234); rd(4'd3, r); chk("R2 control", r, 32'h0000_1234);
    // R11 read data holds without a read strobe
    wr(4'd3, 32'h0000_0000);
    repeat (3) @(negedge clk);
    chk("R11 rdata held", bus_rdata, 32'h0000_1234);

    // vector table: loopback frames in integer baud mode
    wr(4'd0, 32'd2);
    loop_en = 1'b1;
    for (int v = 0; v < 6; v++) begin
      wr(4'd3, C_BASE | (VEC[v][1] ? C_PAR : 32'd0));
      wr(4'd1, {24'd0, VEC[v][9:2]});
      cap_tx(32, VEC[v][1], found, st, d, p, sp);
      chk("R3 frame seen", {31'd0, found}, 32'd1);
      chk("R3 start bit", {31'd0, st}, 32'd0);
      chk("R3 data bits", {24'd0, d}, {24'd0, VEC[v][9:2]});
      if (VEC[v][1]) chk("R3 odd parity", {31'd0, p}, {31'd0, VEC[v][0]});
      chk("R3 stop bit", {31'd0, sp}, 32'd1);
      wait_rx(s);
      chk("R6 status avail", s, 32'd1);
      rd(4'd2, r); chk("R6 rx char", r, {24'd0, VEC[v][9:2]});
      rd(4'd5, r); chk("R6 avail cleared", r, 32'd0);
    end

    // R4 fractional mode: reload 16384 gives 64-clock bits
    wr(4'd0, 32'd16384);
    wr(4'd3, C_BASE | C_FRAC);
    wr(4'd1, 32'h5A);
    cap_tx(64, 1'b0, found, st, d, p, sp);
    chk("R4 fractional byte", {23'd0, found, d}, {23'd0, 1'b1, 8'h5A});
    chk("R4 fractional stop", {31'd0, sp}, 32'd1);
    wait_rx(s); rd(4'd2, r); chk("R4 fractional rx", r, 32'h5A);
    wr(4'd0, 32'd2);

    // R5 second write while full is dropped
    wr(4'd3, 32'd0);
    wr(4'd1, 32'h11);
    wr(4'd1, 32'h22);
    rd(4'd5, r); chk("R5 full flag", r, 32'h200);
    wr(4'd3, C_BASE);
    cap_tx(32, 1'b0, found, st, d, p, sp);
    chk("R5 first char kept", {23'd0, found, d}, {23'd0, 1'b1, 8'h11});
    rd(4'd5, r); chk("R5 full cleared by load", r & 32'h200, 32'd0);
    wait_rx(s); rd(4'd2, r); chk("R5 loopback char", r, 32'h11);
    loop_en = 1'b0;

    // R9 transmit flush
    wr(4'd3, 32'd0);
    wr(4'd1, 32'h33);
    wr(4'd8, 32'd0); rd(4'd5, r); chk("R9 txreset bit0=0 ignored", r, 32'h200);
    wr(4'd8, 32'd1); rd(4'd5, r); chk("R9 txreset clears", r, 32'd0);
    wr(4'd3, C_BASE);
    low_cycles(600, lc); chk("R9 flushed char not sent", lc, 32'd0);

    // R9 receive flush
    send_rx(8'h44, 1'b0, 1'b0, 1'b0);
    rd(4'd5, r); chk("R9 rx avail before flush", r, 32'd1);
    wr(4'd9, 32'd0); rd(4'd5, r); chk("R9 rxreset bit0=0 ignored", r, 32'd1);
    wr(4'd9, 32'd1); rd(4'd5, r); chk("R9 rxreset clears", r, 32'd0);

    // R8 parity fault: 0x01 with parity bit 1 has an even count
    wr(4'd3, C_BASE | C_PAR);
    send_rx(8'h01, 1'b1, 1'b1, 1'b0);
    rd(4'd5, r); chk("R8 parity error flag", r, 32'h5);
    rd(4'd2, r); chk("R8 char still stored", r, 32'h01);
    rd(4'd5, r); chk("R8 cleared by read", r, 32'd0);
    send_rx(8'h01, 1'b1, 1'b0, 1'b0);
    rd(4'd5, r); chk("R8 good parity no error", r, 32'h1);
    rd(4'd2, r); chk("R6 good parity char", r, 32'h01);

    // R8 low stop bit, then R9 flush of the error
    wr(4'd3, C_BASE);
    send_rx(8'h7E, 1'b0, 1'b0, 1'b1);
    rd(4'd5, r); chk("R8 stop error flag", r, 32'h5);
    wr(4'd9, 32'd1); rd(4'd5, r); chk("R9 rxreset clears error", r, 32'd0);

    // R7 short low glitch is not a start bit
    @(negedge clk); rx_drv = 1'b0; repeat (6) @(negedge clk); rx_drv = 1'b1;
    repeat (200) @(negedge clk);
    rd(4'd5, r); chk("R7 glitch rejected", r, 32'd0);

    // R10 receive disabled, then run off
    wr(4'd3, 32'h0000_0089);
    send_rx(8'h66, 1'b0, 1'b0, 1'b0);
    rd(4'd5, r); chk("R10 rx disabled", r, 32'd0);
    wr(4'd3, 32'd0);
    wr(4'd1, 32'h77);
    low_cycles(600, lc); chk("R10 no send while stopped", lc, 32'd0);
    rd(4'd5, r); chk("R10 full kept while stopped", r, 32'h200);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule